// File: doc/BRIEF.md
# Late-Write Pipelined SRAM with Byte-Lane Bypass

This block models a synchronous single-port memory whose writes use late-write timing. A command carries the address, the select, the write enable and four byte-lane enables, and it is taken on one rising clock edge. The data for a write is taken on the next rising edge. The captured write waits in a pending register. It enters the storage array only when the following write arrives, so that the array port does one write per write command and the data is never late for its own slot.

A read that targets the pending address is served lane by lane. Lanes enabled in the pending write come from the pending register, and the other lanes come from the array. Read results leave through an output register one cycle after the read command. They stay unchanged until another read is performed.

A sleep input freezes the command path and turns off the output drive while keeping the stored data. An output-enable input gates a separate drive-enable output that marks when the data-out bus would be driven.

Top module: `lw_sram`

## Requirements
- R1: Address, select, write enable and lane enables are taken at one rising edge. A write's data is taken from `wdata` at the next rising edge, and `wdata` at the command edge has no effect.
- R2: A read command taken at edge N places its word on `rdata` after edge N+1. `rdata` changes at no other time.
- R3: A read of the address of the pending write returns the newly written lanes, even though the array has not yet been updated.
- R4: Lane i is bits [9i+8:9i] and is written only when `lane_we[i]` is 1. On a read that hits the pending address, enabled lanes come from the pending data and the other lanes come from the array.
- R5: A pending write is committed to the array when the next write command takes effect. The data then stays readable after later writes to other addresses.
- R6: A cycle with `sel` low neither reads nor writes. It leaves the pending write and `rdata` unchanged.
- R7: A write with all lane enables at 0 changes no stored lane. It still becomes the pending write and so commits the previous one.
- R8: Consecutive reads of the same address keep `rdata` constant.
- R9: While `sleep` is 1, command inputs are ignored, `rdata_drv` is 0 and the stored contents are kept.
- R10: `rdata_drv` equals `oe` whenever `sleep` is 0.
- R11: While `rst_n` is 0 at a rising edge, the output register clears to 0 and the pending write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep | input | 1 | Low-power hold; freezes commands, output drive off |
| sel | input | 1 | Command select; 0 means no operation |
| wr_en | input | 1 | 1 = write command, 0 = read command |
| lane_we | input | 4 | Per-lane write enables, lane i = data bits [9i+8:9i] |
| addr | input | ADDR_W (6) | Word address |
| wdata | input | 36 | Write data, taken one edge after its write command |
| oe | input | 1 | Output enable |
| rdata | output | 36 | Registered read data |
| rdata_drv | output | 1 | Data-out drive enable (0 = high impedance) |

## Verification
The assertions assume that `sleep` rises only after a cycle in which no write command was issued, so that no write data is still due. They also assume `rst_n` is low for at least one rising edge before use. The stimulus keeps to this by entering a sleep burst only when the previous step left no write data outstanding. Inside a burst the command pins keep toggling, so the check that they are ignored is real. Addresses are drawn mostly from a small set so that reads often hit the pending write with partial lane masks.

// File: rtl/lw_sram_pkg.sv
// Package: shared operation encoding for the late-write memory.
// Assumes: one operation at most per clock edge.
package lw_sram_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } lw_op_e;
endpackage

// File: rtl/lw_cmd_stage.sv
// Module: command capture stage.
// Takes address, select, write enable and lane enables at a rising edge and
// decodes them into one operation acted on at the next edge.
// Assumes: sleep is already synchronous to clk.
module lw_cmd_stage
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep,
    input  logic              sel,
    input  logic              wr_en,
    input  logic [LANES-1:0]  lane_we,
    input  logic [ADDR_W-1:0] addr,
    output lw_op_e            op_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [LANES-1:0]  lanes_q
);

    // Decode the operation; sleep and deselect both yield an idle slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= OP_IDLE;
        end else if (sleep || !sel) begin
            op_q <= OP_IDLE;
        end else begin
            op_q <= wr_en ? OP_WRITE : OP_READ;
        end
    end

    // Hold address and lane mask of the last accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            lanes_q <= '0;
        end else if (!sleep && sel) begin
            addr_q  <= addr;
            lanes_q <= lane_we;
        end
    end

    AST_SLEEP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (op_q == OP_IDLE)); // R9

endmodule

// File: rtl/lw_array.sv
// Module: storage array with per-lane write strobes.
// One write port and one combinational read port; each lane is a separate
// memory so that a lane mask needs no read-modify-write.
// Assumes: contents are not reset; callers write before reading.
module lw_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [LANES-1:0]  wlanes,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Write this lane when the commit strobe and its lane bit are set.
        always_ff @(posedge clk) begin
            if (we && wlanes[g]) begin
                mem[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
    end

endmodule

// File: rtl/lw_hold_reg.sv
// Module: pending-write register with commit and lane bypass.
// A load parks a new write here and, if one was already parked, hands the
// old one to the array in the same edge. Reads are merged lane by lane.
// Assumes: load and a read merge never use the same edge.
module lw_hold_reg #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [LANES-1:0]  load_lanes,
    input  logic [DATA_W-1:0] load_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] arr_word,
    output logic [DATA_W-1:0] merged,
    output logic              commit_en,
    output logic [ADDR_W-1:0] commit_addr,
    output logic [LANES-1:0]  commit_lanes,
    output logic [DATA_W-1:0] commit_data
);

    logic              pend_valid;
    logic [ADDR_W-1:0] pend_addr;
    logic [LANES-1:0]  pend_lanes;
    logic [DATA_W-1:0] pend_data;
    logic              hit;

    // Park each new write; earlier contents leave through the commit port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_addr  <= '0;
            pend_lanes <= '0;
            pend_data  <= '0;
        end else if (load) begin
            pend_valid <= 1'b1;
            pend_addr  <= load_addr;
            pend_lanes <= load_lanes;
            pend_data  <= load_data;
        end
    end

    assign commit_en    = load && pend_valid;
    assign commit_addr  = pend_addr;
    assign commit_lanes = pend_lanes;
    assign commit_data  = pend_data;
    assign hit          = pend_valid && (pend_addr == rd_addr);

    for (genvar g = 0; g < LANES; g++) begin : g_merge
        assign merged[g*LANE_W +: LANE_W] = (hit && pend_lanes[g])
            ? pend_data[g*LANE_W +: LANE_W]
            : arr_word[g*LANE_W +: LANE_W];
    end

    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(pend_addr) && $stable(pend_data) && $stable(pend_lanes))); // R6
    AST_LOAD_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (pend_valid && pend_addr == $past(load_addr))); // R3

endmodule

// File: rtl/lw_sram.sv
// Module: late-write pipelined memory, top level.
// Command at edge N, write data at edge N+1, commit at the next write,
// read data registered after edge N+1, lane-wise bypass from the pending
// write. Sleep freezes commands and drops the drive enable.
// Assumes: sleep is raised only when no write data is still due.
module lw_sram
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep,
    input  logic              sel,
    input  logic              wr_en,
    input  logic [LANES-1:0]  lane_we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              oe,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_drv
);

    lw_op_e            op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LANES-1:0]  lanes_q;
    logic [DATA_W-1:0] arr_word;
    logic [DATA_W-1:0] merged;
    logic              commit_en;
    logic [ADDR_W-1:0] commit_addr;
    logic [LANES-1:0]  commit_lanes;
    logic [DATA_W-1:0] commit_data;
    logic [DATA_W-1:0] dout_q;

    lw_cmd_stage #(.ADDR_W(ADDR_W), .LANES(LANES)) cmd_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sleep   (sleep),
        .sel     (sel),
        .wr_en   (wr_en),
        .lane_we (lane_we),
        .addr    (addr),
        .op_q    (op_q),
        .addr_q  (addr_q),
        .lanes_q (lanes_q)
    );

    lw_hold_reg #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) hold_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (op_q == OP_WRITE),
        .load_addr    (addr_q),
        .load_lanes   (lanes_q),
        .load_data    (wdata),
        .rd_addr      (addr_q),
        .arr_word     (arr_word),
        .merged       (merged),
        .commit_en    (commit_en),
        .commit_addr  (commit_addr),
        .commit_lanes (commit_lanes),
        .commit_data  (commit_data)
    );

    lw_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) array_i (
        .clk    (clk),
        .we     (commit_en),
        .waddr  (commit_addr),
        .wlanes (commit_lanes),
        .wdata  (commit_data),
        .raddr  (addr_q),
        .rdata  (arr_word)
    );

    // Output register: loaded only by a read operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= '0;
        end else if (op_q == OP_READ) begin
            dout_q <= merged;
        end
    end

    assign rdata     = dout_q;
    assign rdata_drv = oe && !sleep;

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q != OP_READ) |=> $stable(dout_q)); // R2
    AST_SAME_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (op_q == OP_READ && $past(op_q) == OP_READ && addr_q == $past(addr_q))
        |=> $stable(dout_q)); // R8

endmodule

// File: tb/lw_sram_tb.sv
// Bench: directed corner cases plus seeded random traffic. Expected read
// data comes from a lane-masked word model updated when write data is driven.
module lw_sram_tb_top;

    localparam int ADDR_W = 6;
    localparam int DW     = 36;
    localparam int NWORDS = 1 << ADDR_W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sleep = 1'b0;
    logic          sel = 1'b0;
    logic          wr_en = 1'b0;
    logic [3:0]    lane_we = '0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          oe = 1'b1;
    logic [DW-1:0] rdata;
    logic          rdata_drv;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [DW-1:0] model [NWORDS];

    bit            wpend = 1'b0;
    logic [ADDR_W-1:0] wp_addr;
    logic [3:0]    wp_lanes;
    logic [DW-1:0] wp_data;

    bit            p1_rd = 1'b0, p2_rd = 1'b0;
    logic [DW-1:0] p1_exp, p2_exp;
    string         p1_tag = "", p2_tag = "";
    logic [DW-1:0] hold_val = '0;

    always #10 clk = ~clk;

    lw_sram #(.ADDR_W(ADDR_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep     (sleep),
        .sel       (sel),
        .wr_en     (wr_en),
        .lane_we   (lane_we),
        .addr      (addr),
        .wdata     (wdata),
        .oe        (oe),
        .rdata     (rdata),
        .rdata_drv (rdata_drv)
    );

    function automatic logic [DW-1:0] rand36();
        return {$urandom() % 16, $urandom()};
    endfunction

    function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old_w,
                                                 input logic [DW-1:0] new_w,
                                                 input logic [3:0] ln);
        logic [DW-1:0] r = old_w;
        for (int i = 0; i < 4; i++)
            if (ln[i]) r[i*9 +: 9] = new_w[i*9 +: 9];
        return r;
    endfunction

    task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock step: check the result due now, drive a new command.
    task automatic step(input bit s, input bit w, input logic [3:0] ln,
                        input logic [ADDR_W-1:0] a, input bit slp, input bit o,
                        input string tag);
        bit eff;
        bit rd;
        logic [DW-1:0] ex;
        @(negedge clk);
        if (p2_rd) chk(rdata, p2_exp, p2_tag);
        else       chk(rdata, hold_val, "R6 output held");
        hold_val = rdata;
        if (wpend) begin
            wdata = wp_data;
            model[wp_addr] = lane_merge(model[wp_addr], wp_data, wp_lanes);
        end else begin
            wdata = rand36();   // R1: value at a command edge has no effect
        end
        eff = s && !slp;
        rd  = eff && !w;
        ex  = model[a];
        wpend = eff && w;
        if (wpend) begin
            wp_addr  = a;
            wp_lanes = ln;
            wp_data  = rand36();
        end
        sel = s; wr_en = w; lane_we = ln; addr = a; sleep = slp; oe = o;
        #1;
        chk({35'd0, rdata_drv}, {35'd0, o && !slp}, slp ? "R9 drive off" : "R10 drive");
        p2_rd = p1_rd; p2_exp = p1_exp; p2_tag = p1_tag;
        p1_rd = rd;    p1_exp = ex;     p1_tag = tag;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int slp_left = 0;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(rdata, '0, "R11 reset output");
        chk({35'd0, rdata_drv}, 36'd1, "R11 drive follows oe");
        rst_n = 1'b1;

        // Fill every word, then read back (R1 data one edge after command).
        for (int i = 0; i < NWORDS; i++) step(1, 1, 4'hF, i[ADDR_W-1:0], 0, 1, "R1");
        for (int i = 0; i < NWORDS; i++) step(1, 0, 4'h0, i[ADDR_W-1:0], 0, 1, "R1 R5");

        // R3/R4: partial write then immediate read of the pending address.
        step(1, 1, 4'b0101, 6'd5, 0, 1, "R4");
        step(1, 0, 4'h0,    6'd5, 0, 1, "R4 partial bypass");
        step(1, 1, 4'hF,    6'd6, 0, 1, "R3");
        step(1, 0, 4'h0,    6'd6, 0, 1, "R3 full bypass");

        // R7: empty-mask write commits the previous one and changes nothing.
        step(1, 1, 4'h0, 6'd7, 0, 1, "R7");
        step(1, 1, 4'hF, 6'd9, 0, 1, "R7");
        step(1, 0, 4'h0, 6'd6, 0, 1, "R7 R5 committed");
        step(1, 0, 4'h0, 6'd7, 0, 1, "R7 unchanged");

        // R6: deselected cycles with write pins active do nothing.
        for (int i = 0; i < 4; i++) step(0, 1, 4'hF, 6'd9, 0, 1, "R6");
        step(1, 0, 4'h0, 6'd9, 0, 1, "R6 pending intact");

        // R8: repeated reads of one address.
        for (int i = 0; i < 4; i++) step(1, 0, 4'h0, 6'd9, 0, 1, "R8");

        // R10: output enable low.
        step(0, 0, 4'h0, 6'd0, 0, 0, "R10");
        step(0, 0, 4'h0, 6'd0, 0, 1, "R10");

        // R9: sleep with active write commands on the pins.
        for (int i = 0; i < 3; i++) step(1, 1, 4'hF, 6'd9, 1, 1, "R9");
        step(1, 0, 4'h0, 6'd9, 0, 1, "R9 contents kept");

        // Seeded random traffic with occasional sleep bursts.
        for (int n = 0; n < 4000; n++) begin
            bit s, w, slp, o;
            logic [3:0] ln;
            logic [ADDR_W-1:0] a;
            if (slp_left == 0 && !wpend && ($urandom() % 80 == 0)) slp_left = 3;
            slp = (slp_left > 0);
            if (slp_left > 0) slp_left--;
            s  = ($urandom() % 8) != 0;
            w  = $urandom() % 2;
            ln = $urandom() % 16;
            a  = ($urandom() % 4 == 0) ? ADDR_W'($urandom()) : ADDR_W'($urandom() % 4);
            o  = ($urandom() % 8) != 0;
            step(s, w, ln, a, slp, o, "R3 R4 R5 random");
        end

        step(0, 0, 4'h0, 6'd0, 0, 1, "R2 drain");
        step(0, 0, 4'h0, 6'd0, 0, 1, "R2 drain");
        step(0, 0, 4'h0, 6'd0, 0, 1, "R2 drain");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule